// File: doc/BRIEF.md
# Trigger-to-Trigger Cycle Timer

This block measures how many clock periods separate two events. It watches two single-bit trigger inputs, one that opens a measurement window and one that closes it. Each trigger first passes through a two-flop synchroniser. Its rising edge is then found by comparing the synchronised level with the level one cycle earlier. From the opening edge onward, a counter advances once per clock. When the closing edge is seen, the counter freezes and a completion flag rises.

The result is the number of clock rising edges that fall strictly after the start trigger rises and strictly before the stop trigger rises. A clock edge that coincides with the stop trigger's rising edge is left out. The counter saturates at 2^CNT_W and does not wrap, so the result bus is CNT_W+1 bits wide. One measurement is taken per reset. After completion the result and flag hold until the next reset, and triggers are ignored. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `cycle_span_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, `span_o` reads 0 and `done_o` reads 0.
- R2: With triggers changed between clock edges, let the first edge that samples start high be edge s and the first edge that samples stop high be edge p. The final `span_o` equals p-s, the edges from s through p-1. Edge p itself is not counted.
- R3: The shortest legal window, a stop one clock period after the start, yields a result of 1.
- R4: `done_o` stays 0 after edges p and p+1 and is 1 after edge p+2, with the final `span_o` presented in that same cycle.
- R5: `span_o` never exceeds 2^CNT_W. A window of 2^CNT_W or more periods reports exactly 2^CNT_W, and the count never wraps.
- R6: A stop rising edge seen before any start rising edge is ignored: `done_o` stays 0, `span_o` stays 0, and a later start/stop pair measures normally.
- R7: Once `done_o` is 1, `done_o` and `span_o` hold unchanged until reset, whatever the triggers do.
- R8: Only rising edges act. A start held high for several cycles opens the window once, and a further start edge during a measurement does not restart the count.
- R9: Asserting reset during a measurement clears the block to the R1 state, and a fresh measurement afterwards reports its own window length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counting is in rising edges of this clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| start_trig_i | input | 1 | Opens the window on its rising edge |
| stop_trig_i | input | 1 | Closes the window on its rising edge |
| span_o | output | CNT_W+1 | Counted clock edges, saturating at 2^CNT_W |
| done_o | output | 1 | High once a measurement has completed |

## Verification
The hardest state to reach from the ports is the run that has already saturated. The counter must sit at 2^CNT_W for many cycles while the stop edge is still pending, and it must neither wrap nor move. The bench builds the block with a narrow counter (CNT_W of 4) so that windows of 16, 17 and 30 periods drive it to the ceiling and beyond in a few dozen cycles. The second hard case is telling an ignored trigger apart from a lost one. To do this, the bench follows a lone stop pulse, a late restart pulse or a post-completion pulse pair with a check of the held outputs, or with a normal measurement whose length must still come out exact.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HELD = 2'd2
  } span_state_e;
endpackage

// File: rtl/cst_rst_sync.sv
module cst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_d;

  always_comb begin
    chain_d = {chain_q[MSB-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[MSB];
endmodule

// File: rtl/cst_trig_edge.sv
module cst_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;
  logic         prev_q;
  logic         prev_d;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], trig_i};
    prev_d = sync_q[MSB];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // level now high, one cycle ago low
  assign rise_o = sync_q[MSB] & ~prev_q;
endmodule

// File: rtl/cst_span_ctrl.sv
module cst_span_ctrl
  import cst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_rise_i,
  input  logic         stop_rise_i,
  output logic [CNT_W:0] span_o,
  output logic         done_o
);
  localparam int               OUT_W    = CNT_W + 1;
  localparam logic [OUT_W-1:0] SPAN_MAX = OUT_W'(1) << CNT_W;

  span_state_e      state_q, state_d;
  logic [OUT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_clr, cnt_adv, cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rise_i) begin
          state_d = ST_RUN;
          cnt_clr = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_adv = 1'b1;
        if (stop_rise_i) begin
          state_d = ST_HELD;
        end
      end
      ST_HELD: begin
        state_d = ST_HELD;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    cnt_inc = (cnt_q == SPAN_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_d   = cnt_clr ? '0 : cnt_inc;
    cnt_en  = cnt_clr | cnt_adv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign span_o = cnt_q;
  assign done_o = (state_q == ST_HELD);
endmodule

// File: rtl/cycle_span_timer.sv
module cycle_span_timer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_trig_i,
  input  logic           stop_trig_i,
  output logic [CNT_W:0] span_o,
  output logic           done_o
);
  localparam int N_TRIG = 2;

  logic              rst_n_sync;
  logic [N_TRIG-1:0] trig_vec;
  logic [N_TRIG-1:0] rise_vec;
  logic              start_rise;
  logic              stop_rise;

  cst_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign trig_vec = {stop_trig_i, start_trig_i};

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    cst_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n_sync),
      .trig_i (trig_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  assign start_rise = rise_vec[0];
  assign stop_rise  = rise_vec[1];

  cst_span_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .start_rise_i (start_rise),
    .stop_rise_i  (stop_rise),
    .span_o       (span_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/cst_span_chk.sv
module cst_span_chk #(
  parameter int CNT_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_rise_i,
  input logic           stop_rise_i,
  input logic [CNT_W:0] span_i,
  input logic           done_i
);
  localparam int               OUT_W    = CNT_W + 1;
  localparam logic [OUT_W-1:0] SPAN_MAX = OUT_W'(1) << CNT_W;

  // R5
  span_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_i <= SPAN_MAX);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (done_i && $stable(span_i)));

  // R4
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(stop_rise_i));

  // R2
  span_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, span_i} >= {1'b0, $past(span_i)}) &&
    ({1'b0, span_i} <= {1'b0, $past(span_i)} + 1'b1));

  // R6
  stop_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && span_i == '0 && stop_rise_i && !start_rise_i && !$past(start_rise_i))
      |=> !done_i);
endmodule

bind cycle_span_timer cst_span_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_sync),
  .start_rise_i (start_rise),
  .stop_rise_i  (stop_rise),
  .span_i       (span_o),
  .done_i       (done_o)
);

// File: tb/cycle_span_timer_tb_top.sv
`timescale 1ns/1ps
module cycle_span_timer_tb_top;
  localparam int CNT_W = 4;
  localparam int SMAX  = 1 << CNT_W;
  localparam int NVEC  = 8;
  // gap (periods), start width (periods), expected span
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 1}, '{2, 1, 2}, '{5, 3, 5}, '{15, 1, 15},
    '{16, 2, 16}, '{17, 1, 16}, '{30, 5, 16}, '{7, 7, 7}
  };

  logic           clk;
  logic           rst_ni;
  logic           start_trig;
  logic           stop_trig;
  logic [CNT_W:0] span;
  logic           done;
  int             n_chk;
  int             n_err;

  cycle_span_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_trig_i (start_trig),
    .stop_trig_i  (stop_trig),
    .span_o       (span),
    .done_o       (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; start_trig = 1'b0; stop_trig = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drives one window; restart>0 adds a one-period start pulse at that offset.
  task automatic drive_window(input int gap, input int sw, input int restart);
    @(negedge clk);
    start_trig = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i == sw) start_trig = 1'b0;
      if (restart > 0 && i == restart) start_trig = 1'b1;
      if (restart > 0 && i == restart + 1) start_trig = 1'b0;
    end
    stop_trig = 1'b1;
  endtask

  task automatic measure(input int gap, input int sw, input int restart,
                         input int exp, input string req);
    drive_window(gap, sw, restart);
    @(negedge clk);
    check(done == 1'b0, "R4", done, 0);
    stop_trig = 1'b0; start_trig = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R4", done, 0);
    @(negedge clk);
    check(done == 1'b1, "R4", done, 1);
    check(int'(span) == exp, req, span, exp);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_ni = 1'b0; start_trig = 1'b0; stop_trig = 1'b0;
    #1;
    check(span == '0 && done == 1'b0, "R1", span, 0);
    do_reset();
    check(span == '0 && done == 1'b0, "R1", span, 0);

    // table walk: R2, R3 (gap 1), R5 (gaps >= 16)
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      measure(VEC[v][0], VEC[v][1], 0, VEC[v][2],
              (VEC[v][0] == 1) ? "R3" : (VEC[v][2] == SMAX) ? "R5" : "R2");
    end

    // R6: lone stop pulse is ignored, then a normal window
    do_reset();
    @(negedge clk); stop_trig = 1'b1;
    repeat (2) @(negedge clk); stop_trig = 1'b0;
    repeat (6) @(negedge clk);
    check(done == 1'b0, "R6", done, 0);
    check(span == '0, "R6", span, 0);
    repeat (2) @(negedge clk);
    measure(4, 1, 0, 4, "R6");

    // R7: a second pair after completion changes nothing
    drive_window(7, 1, 0);
    @(negedge clk); stop_trig = 1'b0;
    repeat (12) @(negedge clk);
    check(done == 1'b1, "R7", done, 1);
    check(int'(span) == 4, "R7", span, 4);

    // R8: long start level counts once; restart edge mid-run ignored
    do_reset();
    measure(6, 4, 0, 6, "R8");
    do_reset();
    measure(9, 1, 4, 9, "R8");

    // R9: reset during a run, then a fresh window
    do_reset();
    @(negedge clk); start_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(span == '0 && done == 1'b0, "R9", span, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(span == '0 && done == 1'b0, "R9", span, 0);
    measure(3, 1, 0, 3, "R9");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2: watchdog expired, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule